// File: doc/BRIEF.md
# Synchronous Master Serial Transmitter

This block sends words over a two-wire synchronous link, acting as the clock master. It drives a serial clock line and a serial data line and shifts out 8-bit words, or 9-bit words when the extra-bit mode is on. Bit 0 goes out first. The host writes each word into a one-entry holding buffer. The word moves into the shift register as soon as the shifter is free: right away if the shifter is idle, or at the end of the last bit of the word in flight. A buffer that is refilled in time therefore gives a continuous stream with no gap between words.

Two status flags report the state of the block. One shows that the holding buffer is empty and can take another word. The other shows that the shift register holds nothing. The buffer-empty flag, ANDed with an enable, forms the interrupt output. A 16-bit divider sets the bit rate, and a polarity input selects the level of the clock line when it is idle. The link is half-duplex, so a receive-inhibit output is high whenever transmission is enabled.

Top module: `sync_tx_master`

## Requirements
- R1: Words are shifted only while port_en, sync_mode, master_mode and tx_en are all 1. While any of them is 0, shift_empty stays 1, sclk_o stays at its idle level, and a written word waits in the buffer.
- R2: When no word is being sent, sclk_o equals ck_idle_hi. During each bit it first takes the opposite level and then returns to the idle level.
- R3: Data goes out bit 0 first. sdata_o changes only on the sclk_o edge that leaves the idle level, and it holds its value until the clock has returned to idle.
- R4: One bit lasts 4*(div_val+1) clock cycles. sclk_o is at the non-idle level for the first 2*(div_val+1) cycles of the bit.
- R5: A word written while the shifter is empty is loaded on the next clock edge. Its bit 0 and the non-idle clock level appear after that edge. A word waiting at the end of the last bit is loaded at once, with no gap between words.
- R6: buf_empty is 1 after reset. It goes to 0 on the edge that accepts a write, and it returns to 1 only on the edge where the word moves into the shifter.
- R7: irq equals buf_empty AND irq_en.
- R8: shift_empty is 0 from the load edge until the end of the last bit. If no word is waiting, shift_empty then returns to 1 and sclk_o stays idle.
- R9: With word9 = 1 at load time, the value written on wr_bit8 is sent as a ninth bit after bit 7. With word9 = 0, exactly 8 bits are sent.
- R10: rx_inhibit is 1 one cycle after all four enables are 1, and 0 one cycle after any of them is 0. It is always 1 while shift_empty is 0.
- R11: Clearing tx_en stops the current word. On the next edge sclk_o goes idle and shift_empty becomes 1. A word in the buffer is kept and is sent once tx_en is set again.
- R12: After reset, sclk_o is idle, irq is 0 with irq_en = 0, and rx_inhibit is 0 while the enables are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| port_en | input | 1 | Serial port enable |
| sync_mode | input | 1 | Synchronous mode select |
| master_mode | input | 1 | Clock master select |
| tx_en | input | 1 | Transmit enable |
| ck_idle_hi | input | 1 | Idle level of sclk_o (1 = high) |
| word9 | input | 1 | Send a ninth bit per word |
| div_val | input | DIV_W | Bit rate divider |
| wr_valid | input | 1 | Write strobe into the holding buffer |
| wr_data | input | DATA_W | Data bits of the written word |
| wr_bit8 | input | 1 | Ninth bit of the written word |
| irq_en | input | 1 | Interrupt enable for buffer-empty |
| sclk_o | output | 1 | Serial clock line |
| sdata_o | output | 1 | Serial data line |
| buf_empty | output | 1 | Holding buffer empty |
| shift_empty | output | 1 | Shift register empty |
| irq | output | 1 | Buffer-empty interrupt |
| rx_inhibit | output | 1 | Receive inhibit while transmitting |

## Verification
The bench uses the default widths, DATA_W = 8 and DIV_W = 16. It drives div_val with 0 and 3. With divider 0, every bit lasts four cycles, so the exact load edge, the clock half-period and the back-to-back transfer can be checked cycle by cycle. With divider 3, a word is long enough to disable it midway through a bit and check the abort.

// File: rtl/stx_pkg.sv
package stx_pkg;
  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_SHIFT = 1'b1
  } stx_state_e;

  localparam logic [1:0] PH_CK_DROP = 2'd1;
  localparam logic [1:0] PH_BIT_END = 2'd3;
endpackage

// File: rtl/stx_quarter_gen.sv
module stx_quarter_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div_val,
  output logic             q_tick,
  output logic [1:0]       qph
);
  logic [DIV_W-1:0] cnt;

  assign q_tick = run && (cnt >= div_val);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      qph <= 2'd0;
    end else if (cnt >= div_val) begin
      cnt <= '0;
      qph <= qph + 2'd1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assert_phase_restart_R4: assert property (@(posedge clk) disable iff (rst)
    !run |=> (qph == 2'd0 && cnt == '0));
endmodule

// File: rtl/stx_hold_buf.sv
module stx_hold_buf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_bit8,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] hold_data,
  output logic              hold_bit8,
  output logic              buf_empty
);
  logic empty_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      empty_q <= 1'b1;
    end else if (wr_valid) begin
      empty_q <= 1'b0;
    end else if (take) begin
      empty_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_valid) begin
      hold_data <= wr_data;
      hold_bit8 <= wr_bit8;
    end
  end

  assign full      = ~empty_q;
  assign buf_empty = empty_q;

  assert_clear_on_write_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(empty_q) |-> $past(wr_valid));
  assert_set_on_take_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(empty_q) |-> ($past(take) && !$past(wr_valid)));
endmodule

// File: rtl/stx_shifter.sv
module stx_shifter
  import stx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_ok,
  input  logic              nine_sel,
  input  logic              buf_full,
  input  logic [DATA_W-1:0] buf_data,
  input  logic              buf_bit8,
  input  logic              q_tick,
  input  logic [1:0]        qph,
  output logic              take,
  output logic              busy,
  output logic              ck_act,
  output logic              sdata,
  output logic              shift_empty
);
  localparam int WORD_W = DATA_W + 1;
  localparam int CNT_W  = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(DATA_W - 1);

  stx_state_e       state;
  logic [WORD_W-1:0] sh;
  logic [CNT_W-1:0]  bit_idx;
  logic              nine_q;
  logic              last_bit;
  logic              bit_end;

  assign last_bit = (bit_idx == (nine_q ? LAST_LONG : LAST_SHORT));
  assign bit_end  = (state == ST_SHIFT) && q_tick && (qph == PH_BIT_END);
  assign take     = run_ok && buf_full &&
                    ((state == ST_IDLE) || (bit_end && last_bit));

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      ck_act  <= 1'b0;
      sdata   <= 1'b0;
      sh      <= '0;
      bit_idx <= '0;
      nine_q  <= 1'b0;
    end else if (!run_ok) begin
      state  <= ST_IDLE;
      ck_act <= 1'b0;
    end else if (take) begin
      state   <= ST_SHIFT;
      ck_act  <= 1'b1;
      sdata   <= buf_data[0];
      sh      <= {1'b0, buf_bit8, buf_data[DATA_W-1:1]};
      bit_idx <= '0;
      nine_q  <= nine_sel;
    end else if (state == ST_SHIFT && q_tick) begin
      if (qph == PH_CK_DROP) begin
        ck_act <= 1'b0;
      end else if (qph == PH_BIT_END) begin
        if (!last_bit) begin
          sdata   <= sh[0];
          sh      <= sh >> 1;
          bit_idx <= bit_idx + 1'b1;
          ck_act  <= 1'b1;
        end else begin
          state <= ST_IDLE;
        end
      end
    end
  end

  assign busy        = (state == ST_SHIFT);
  assign shift_empty = (state == ST_IDLE);

  assert_idle_clock_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !ck_act);
  assert_abort_R11: assert property (@(posedge clk) disable iff (rst)
    !run_ok |=> (state == ST_IDLE));
  assert_load_R5: assert property (@(posedge clk) disable iff (rst)
    take |=> (state == ST_SHIFT && ck_act));
endmodule

// File: rtl/sync_tx_master.sv
module sync_tx_master #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              port_en,
  input  logic              sync_mode,
  input  logic              master_mode,
  input  logic              tx_en,
  input  logic              ck_idle_hi,
  input  logic              word9,
  input  logic [DIV_W-1:0]  div_val,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_bit8,
  input  logic              irq_en,
  output logic              sclk_o,
  output logic              sdata_o,
  output logic              buf_empty,
  output logic              shift_empty,
  output logic              irq,
  output logic              rx_inhibit
);
  logic              run_ok;
  logic              take;
  logic              full;
  logic [DATA_W-1:0] hold_data;
  logic              hold_bit8;
  logic              busy;
  logic              ck_act;
  logic              q_tick;
  logic [1:0]        qph;

  assign run_ok = port_en & sync_mode & master_mode & tx_en;

  always_ff @(posedge clk) begin
    if (rst) rx_inhibit <= 1'b0;
    else     rx_inhibit <= run_ok;
  end

  stx_hold_buf #(.DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_bit8(wr_bit8), .take(take), .full(full), .hold_data(hold_data),
    .hold_bit8(hold_bit8), .buf_empty(buf_empty)
  );

  stx_quarter_gen #(.DIV_W(DIV_W)) u_qgen (
    .clk(clk), .rst(rst), .run(busy), .div_val(div_val),
    .q_tick(q_tick), .qph(qph)
  );

  stx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .run_ok(run_ok), .nine_sel(word9),
    .buf_full(full), .buf_data(hold_data), .buf_bit8(hold_bit8),
    .q_tick(q_tick), .qph(qph), .take(take), .busy(busy),
    .ck_act(ck_act), .sdata(sdata_o), .shift_empty(shift_empty)
  );

  assign sclk_o = ck_act ^ ck_idle_hi;
  assign irq    = buf_empty & irq_en;

  assert_inhibit_R10: assert property (@(posedge clk) disable iff (rst)
    !shift_empty |-> rx_inhibit);
endmodule

// File: tb/sync_tx_master_tb.sv
module sync_tx_master_tb;
  localparam int DATA_W = 8;
  localparam int DIV_W  = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic port_en = 0, sync_mode = 0, master_mode = 0, tx_en = 0;
  logic ck_idle_hi = 0, word9 = 0, wr_valid = 0, wr_bit8 = 0, irq_en = 0;
  logic [DIV_W-1:0]  div_val = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic sclk_o, sdata_o, buf_empty, shift_empty, irq, rx_inhibit;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  sync_tx_master #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_dut (
    .clk(clk), .rst(rst), .port_en(port_en), .sync_mode(sync_mode),
    .master_mode(master_mode), .tx_en(tx_en), .ck_idle_hi(ck_idle_hi),
    .word9(word9), .div_val(div_val), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_bit8(wr_bit8), .irq_en(irq_en), .sclk_o(sclk_o), .sdata_o(sdata_o),
    .buf_empty(buf_empty), .shift_empty(shift_empty), .irq(irq),
    .rx_inhibit(rx_inhibit)
  );

  // Monitor: records each bit when the clock returns to idle, plus active-edge times.
  logic cap_mem [0:1023];
  int   rise_cyc [0:1023];
  int   cap_n = 0;
  int   rise_n = 0;
  int   unstable = 0;
  logic prev_act = 1'b0;
  logic held = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    logic act;
    act = (sclk_o != ck_idle_hi);
    if (!rst) begin
      if (act && !prev_act) begin
        held = sdata_o;
        if (rise_n < 1024) rise_cyc[rise_n] = cyc;
        rise_n = rise_n + 1;
      end else if (act && prev_act && sdata_o != held) begin
        unstable = unstable + 1;
      end else if (!act && prev_act) begin
        if (cap_n < 1024) cap_mem[cap_n] = sdata_o;
        cap_n = cap_n + 1;
      end
    end
    prev_act = act;
  end

  initial begin
    #1_200_000;
    errors = errors + 1;
    $display("FAIL watchdog: run hung (actual timeout, expected completion)");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc_wait(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic enable_all(input logic v);
    @(negedge clk);
    port_en = v; sync_mode = v; master_mode = v; tx_en = v;
  endtask

  task automatic write_word(input logic [DATA_W-1:0] d, input logic b8);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = d; wr_bit8 = b8;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (shift_empty && buf_empty) break;
    end
    cyc_wait(2);
  endtask

  function automatic logic [31:0] get_bits(input int start, input int n);
    logic [31:0] v;
    v = '0;
    for (int i = 0; i < n; i++) v[i] = cap_mem[start + i];
    return v;
  endfunction

  task automatic spacing(input int start, output int mn, output int mx);
    mn = 1 << 30; mx = 0;
    for (int i = start + 1; i < rise_n; i++) begin
      int d;
      d = rise_cyc[i] - rise_cyc[i-1];
      if (d < mn) mn = d;
      if (d > mx) mx = d;
    end
  endtask

  task automatic t_reset();
    check(sclk_o == 1'b0, "R12 idle clock after reset", sclk_o, 0);
    check(buf_empty == 1'b1, "R6 buf_empty after reset", buf_empty, 1);
    check(shift_empty == 1'b1, "R8 shift_empty after reset", shift_empty, 1);
    check(irq == 1'b0, "R12 irq after reset", irq, 0);
    check(rx_inhibit == 1'b0, "R12 rx_inhibit after reset", rx_inhibit, 0);
  endtask

  task automatic t_exact();
    int c0, r0, mn, mx;
    div_val = 0; ck_idle_hi = 0; word9 = 0;
    enable_all(1'b1);
    cyc_wait(2);
    check(rx_inhibit == 1'b1, "R10 inhibit when enabled", rx_inhibit, 1);
    c0 = cap_n; r0 = rise_n;
    @(negedge clk);
    wr_valid = 1'b1; wr_data = 8'hA5; wr_bit8 = 1'b0;
    @(negedge clk);
    wr_valid = 1'b0;
    check(buf_empty == 1'b0, "R6 buf_empty cleared by write", buf_empty, 0);
    check(shift_empty == 1'b1, "R5 not loaded before next edge", shift_empty, 1);
    @(negedge clk);
    check(shift_empty == 1'b0, "R8 shift_empty low after load", shift_empty, 0);
    check(buf_empty == 1'b1, "R5 buffer emptied on load", buf_empty, 1);
    check(sclk_o == 1'b1, "R2 clock leaves idle on load", sclk_o, 1);
    check(sdata_o == 1'b1, "R3 bit0 on data line", sdata_o, 1);
    @(negedge clk);
    check(sclk_o == 1'b1, "R4 clock active second cycle", sclk_o, 1);
    @(negedge clk);
    check(sclk_o == 1'b0, "R4 clock idle after half bit", sclk_o, 0);
    wait_done();
    check(cap_n - c0 == 8, "R9 eight bits sent", cap_n - c0, 8);
    check(get_bits(c0, 8) == 32'hA5, "R3 LSB-first word", get_bits(c0, 8), 32'hA5);
    spacing(r0, mn, mx);
    check(mn == 4 && mx == 4, "R4 bit period div 0", mx, 4);
    check(unstable == 0, "R3 data stable while clock active", unstable, 0);
    check(sclk_o == 1'b0 && shift_empty == 1'b1, "R8 idle after word", sclk_o, 0);
  endtask

  task automatic t_div_pol();
    int c0, r0, mn, mx;
    @(negedge clk);
    div_val = 3; ck_idle_hi = 1;
    cyc_wait(1);
    check(sclk_o == 1'b1, "R2 idle high with polarity set", sclk_o, 1);
    c0 = cap_n; r0 = rise_n;
    write_word(8'h3C, 1'b0);
    cyc_wait(1);
    check(sclk_o == 1'b0, "R2 active level low", sclk_o, 0);
    wait_done();
    check(get_bits(c0, 8) == 32'h3C && cap_n - c0 == 8, "R3 word with div 3", get_bits(c0, 8), 32'h3C);
    spacing(r0, mn, mx);
    check(mn == 16 && mx == 16, "R4 bit period div 3", mx, 16);
    check(sclk_o == 1'b1, "R2 returns to high idle", sclk_o, 1);
    @(negedge clk);
    ck_idle_hi = 0; div_val = 0;
  endtask

  task automatic t_b2b();
    int c0, r0, mn, mx;
    c0 = cap_n; r0 = rise_n;
    write_word(8'h5A, 1'b0);
    for (int i = 0; i < 50; i++) begin
      if (buf_empty) break;
      @(negedge clk);
    end
    write_word(8'hC3, 1'b0);
    wait_done();
    check(cap_n - c0 == 16, "R5 two words sent", cap_n - c0, 16);
    check(get_bits(c0, 16) == 32'hC35A, "R5 back-to-back order", get_bits(c0, 16), 32'hC35A);
    spacing(r0, mn, mx);
    check(mx == 4, "R5 no gap between words", mx, 4);
  endtask

  task automatic t_nine();
    int c0;
    @(negedge clk); word9 = 1;
    c0 = cap_n;
    write_word(8'h0F, 1'b1);
    wait_done();
    check(cap_n - c0 == 9, "R9 nine bits sent", cap_n - c0, 9);
    check(get_bits(c0, 9) == 32'h10F, "R9 ninth bit one", get_bits(c0, 9), 32'h10F);
    c0 = cap_n;
    write_word(8'hF0, 1'b0);
    wait_done();
    check(get_bits(c0, 9) == 32'h0F0 && cap_n - c0 == 9, "R9 ninth bit zero", get_bits(c0, 9), 32'h0F0);
    @(negedge clk); word9 = 0;
  endtask

  task automatic t_irq_gate();
    int c0;
    @(negedge clk); irq_en = 0;
    @(negedge clk);
    check(irq == 1'b0, "R7 irq masked", irq, 0);
    irq_en = 1;
    @(negedge clk);
    check(irq == 1'b1, "R7 irq when empty and enabled", irq, 1);
    for (int k = 0; k < 4; k++) begin
      enable_all(1'b1);
      @(negedge clk);
      case (k)
        0: port_en = 0;
        1: sync_mode = 0;
        2: master_mode = 0;
        default: tx_en = 0;
      endcase
      cyc_wait(2);
      check(rx_inhibit == 1'b0, "R10 inhibit drops when disabled", rx_inhibit, 0);
      c0 = cap_n;
      write_word(8'h99, 1'b0);
      cyc_wait(30);
      check(shift_empty == 1'b1 && buf_empty == 1'b0, "R1 no shift when an enable is low", shift_empty, 1);
      check(cap_n == c0 && sclk_o == 1'b0, "R1 clock stays idle", cap_n - c0, 0);
      check(irq == 1'b0, "R7 irq low while buffer full", irq, 0);
      enable_all(1'b1);
      wait_done();
      check(get_bits(c0, 8) == 32'h99 && cap_n - c0 == 8, "R1 sends after enabling", get_bits(c0, 8), 32'h99);
    end
    @(negedge clk); irq_en = 0;
  endtask

  task automatic t_abort();
    int c0;
    @(negedge clk); div_val = 3;
    write_word(8'h81, 1'b0);
    for (int i = 0; i < 50; i++) begin
      if (buf_empty) break;
      @(negedge clk);
    end
    write_word(8'h7E, 1'b0);
    cyc_wait(18);
    check(shift_empty == 1'b0, "R11 word in flight before abort", shift_empty, 0);
    tx_en = 0;
    @(negedge clk);
    check(shift_empty == 1'b1, "R11 shifter empty after abort", shift_empty, 1);
    check(sclk_o == 1'b0, "R11 clock idle after abort", sclk_o, 0);
    check(buf_empty == 1'b0, "R11 buffer kept", buf_empty, 0);
    @(negedge clk);
    check(rx_inhibit == 1'b0, "R10 inhibit low after abort", rx_inhibit, 0);
    cyc_wait(20);
    check(buf_empty == 1'b0 && sclk_o == 1'b0, "R11 buffer still held", buf_empty, 0);
    c0 = cap_n;
    tx_en = 1;
    wait_done();
    check(get_bits(c0, 8) == 32'h7E && cap_n - c0 == 8, "R11 kept word sent", get_bits(c0, 8), 32'h7E);
    @(negedge clk); div_val = 0;
  endtask

  initial begin
    cyc_wait(4);
    @(negedge clk); rst = 0;
    @(negedge clk);
    t_reset();
    t_exact();
    t_div_pol();
    t_b2b();
    t_nine();
    t_irq_gate();
    t_abort();
    check(unstable == 0, "R3 data stable across all tests", unstable, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule